// File: doc/BRIEF.md
# Parallel All-Pairs Maximum Finder

This block takes a set of N unsigned operands, each K bits wide, and reports the largest value and the position of the operand that holds it. It does not reduce the operands through a chain of compare-and-select stages. Every pair of operands is compared at the same time. A row-wise AND of the comparison matrix gives a one-hot winner vector. That vector then drives two independent OR planes: one returns the winning value and the other returns the binary index of the winner. Neither plane waits on the other.

Each pair is compared only once. The complement of that single result serves the reverse relation. Equal operands resolve toward the lower position, so the winner vector always has exactly one bit set. The operands are presented packed into one bus, with operand i at bits [i*K +: K]. An optional output register, selected by a parameter, captures the result for timing closure. When it is present, a synchronous active-high reset clears it.

Top module: `amax_find`

## Requirements
- R1: `max_val` equals the largest of the N operands, compared as unsigned K-bit numbers.
- R2: `max_idx` holds the position of an operand whose value equals `max_val`, and exactly one operand is marked as the winner internally.
- R3: When several operands share the maximum value, `max_idx` names the lowest such position; an input with all operands equal yields index 0.
- R4: `max_idx` is plain unsigned binary, `max(1, ceil(log2 N))` bits wide, and never reaches N (for N=5 the last position reads 3'b100).
- R5: With `OUT_REG`=1, both outputs show the result for the operands sampled at a rising clock edge, starting just after that edge (one cycle of latency). With `OUT_REG`=0, both outputs follow the operands combinationally.
- R6: With `OUT_REG`=1, a high `rst` at a rising edge clears `max_val` and `max_idx` to zero, whatever the operands are.
- R7: With N=1, the single operand appears on `max_val` and `max_idx` is 0.
- R8: An input of all-zero operands gives `max_val`=0 and `max_idx`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| operands | input | N*K | Packed operands; operand i occupies bits [i*K +: K] |
| max_val | output | K | Largest operand value |
| max_idx | output | max(1, ceil(log2 N)) | Position of the largest operand, lowest on ties |

## Verification
The bench builds two instances of the block. The first uses N=5 and K=6. Because five is not a power of two, the index encoder has an unused code (5 to 7) that it must never produce, and the top position reads 3'b100. Small random values make multi-way ties frequent, so the lowest-position rule is exercised. The second instance uses N=1 and K=4, which collapses the comparison matrix to its diagonal and checks the pass-through case. Both instances keep the output register enabled, so the scoreboard also confirms the one-cycle latency and the reset clearing.

// File: rtl/amax_pkg.sv
package amax_pkg;

  // Width of the binary position code; at least one bit so N=1 stays legal.
  function automatic int idx_bits(input int n);
    if (n < 2) return 1;
    return $clog2(n);
  endfunction

endpackage

// File: rtl/amax_pair_matrix.sv
// All-pairs comparison matrix. beats[i*N+j] is 1 when operand i wins against j
// under the lowest-position tie rule. One comparator per unordered pair.
module amax_pair_matrix #(
  parameter int N = 8,
  parameter int K = 16
) (
  input  logic [N*K-1:0] opnds,
  output logic [N*N-1:0] beats
);

  for (genvar gi = 0; gi < N; gi++) begin : g_row
    for (genvar gj = 0; gj < N; gj++) begin : g_col
      if (gi == gj) begin : g_diag
        assign beats[gi*N+gj] = 1'b1;
      end else if (gi < gj) begin : g_pair
        logic lo_ge;
        // lower position keeps the win on equality
        assign lo_ge = (opnds[gi*K +: K] >= opnds[gj*K +: K]);
        assign beats[gi*N+gj] = lo_ge;
        assign beats[gj*N+gi] = ~lo_ge;
      end
    end
  end

endmodule

// File: rtl/amax_row_and.sv
// Winner vector: an operand wins when it beats every other operand.
module amax_row_and #(
  parameter int N = 8
) (
  input  logic [N*N-1:0] beats,
  output logic [N-1:0]   win
);

  for (genvar gi = 0; gi < N; gi++) begin : g_win
    assign win[gi] = &beats[gi*N +: N];
  end

endmodule

// File: rtl/amax_onehot_select.sv
// Two independent OR planes driven by the one-hot winner: value and index.
module amax_onehot_select #(
  parameter int N  = 8,
  parameter int K  = 16,
  parameter int IW = 3
) (
  input  logic [N*K-1:0] opnds,
  input  logic [N-1:0]   win,
  output logic [K-1:0]   val,
  output logic [IW-1:0]  idx
);

  always_comb begin
    val = '0;
    for (int i = 0; i < N; i++) begin
      val = val | (opnds[i*K +: K] & {K{win[i]}});
    end
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      idx = idx | (IW'(i) & {IW{win[i]}});
    end
  end

endmodule

// File: rtl/amax_find.sv
module amax_find
  import amax_pkg::*;
#(
  parameter int N       = 8,
  parameter int K       = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N*K-1:0]         operands,
  output logic [K-1:0]           max_val,
  output logic [idx_bits(N)-1:0] max_idx
);

  localparam int IW = idx_bits(N);

  logic [N*N-1:0] beats;
  logic [N-1:0]   win_vec;
  logic [K-1:0]   comb_val;
  logic [IW-1:0]  comb_idx;

  amax_pair_matrix #(.N(N), .K(K)) u_matrix (
    .opnds (operands),
    .beats (beats)
  );

  amax_row_and #(.N(N)) u_rows (
    .beats (beats),
    .win   (win_vec)
  );

  amax_onehot_select #(.N(N), .K(K), .IW(IW)) u_select (
    .opnds (operands),
    .win   (win_vec),
    .val   (comb_val),
    .idx   (comb_idx)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        max_val <= '0;
        max_idx <= '0;
      end else begin
        max_val <= comb_val;
        max_idx <= comb_idx;
      end
    end
  end else begin : g_comb
    assign max_val = comb_val;
    assign max_idx = comb_idx;
  end

  // Checks on the combinational result, sampled at the clock.
  p_onehot_win_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot(win_vec));

  p_idx_range_r4: assert property (@(posedge clk) disable iff (rst)
    int'(comb_idx) < N);

  for (genvar gi = 0; gi < N; gi++) begin : g_chk
    logic [K-1:0] x_op;
    assign x_op = operands[gi*K +: K];

    p_val_bound_r1: assert property (@(posedge clk) disable iff (rst)
      comb_val >= x_op);

    p_val_idx_r2: assert property (@(posedge clk) disable iff (rst)
      (comb_idx == IW'(gi)) |-> (comb_val == x_op));

    p_tie_low_r3: assert property (@(posedge clk) disable iff (rst)
      (comb_idx > IW'(gi)) |-> (x_op < comb_val));
  end

  if (OUT_REG) begin : g_reg_chk
    p_reset_clear_r6: assert property (@(posedge clk)
      $past(rst) |-> (max_val == '0 && max_idx == '0));
  end

endmodule

// File: tb/amax_find_bench.sv
module amax_find_bench;

  localparam int NA = 5;
  localparam int KA = 6;
  localparam int IA = 3;
  localparam int NB = 1;
  localparam int KB = 4;

  logic clk = 1'b0;
  logic rst;
  always #5 clk = ~clk;

  logic [NA*KA-1:0] opa;
  logic [KA-1:0]    va;
  logic [IA-1:0]    ia;
  logic [KB-1:0]    opb;
  logic [KB-1:0]    vb;
  logic             ib;

  amax_find #(.N(NA), .K(KA), .OUT_REG(1'b1)) u_amax_find (
    .clk      (clk),
    .rst      (rst),
    .operands (opa),
    .max_val  (va),
    .max_idx  (ia)
  );

  amax_find #(.N(NB), .K(KB), .OUT_REG(1'b1)) u_amax_find_single (
    .clk      (clk),
    .rst      (rst),
    .operands (opb),
    .max_val  (vb),
    .max_idx  (ib)
  );

  typedef struct {
    int    ev;
    int    ei;
    int    evb;
    string tag;
  } exp_t;

  exp_t sbq[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [NA*KA-1:0] pack5(input int v0, input int v1,
      input int v2, input int v3, input int v4);
    return {KA'(v4), KA'(v3), KA'(v2), KA'(v1), KA'(v0)};
  endfunction

  // Driver: applies operands at a falling edge and pushes the expected result.
  task automatic drive(input logic [NA*KA-1:0] a, input logic [KB-1:0] b,
                       input string tag);
    exp_t e;
    int best;
    int bi;
    @(negedge clk);
    opa = a;
    opb = b;
    best = int'(a[KA-1:0]);
    bi = 0;
    for (int i = 1; i < NA; i++) begin
      if (int'(a[i*KA +: KA]) > best) begin
        best = int'(a[i*KA +: KA]);
        bi = i;
      end
    end
    e.ev  = best;
    e.ei  = bi;
    e.evb = int'(b);
    e.tag = tag;
    sbq.push_back(e);
  endtask

  // Monitor: one cycle after each push the registered result is compared (R5).
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        chk({e.tag, " R1 R5 value"}, int'(va), e.ev);
        chk({e.tag, " index"}, int'(ia), e.ei);
        chk("R7 single value", int'(vb), e.evb);
        chk("R7 single index", int'(ib), 0);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R5 actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [NA*KA-1:0] a;
    rst = 1'b1;
    opa = '1;
    opb = '1;
    repeat (3) @(posedge clk);
    #2;
    // R6: reset clears both outputs despite all-ones operands
    chk("R6 value", int'(va), 0);
    chk("R6 index", int'(ia), 0);
    chk("R6 single value", int'(vb), 0);
    @(negedge clk);
    rst = 1'b0;

    drive(pack5(63, 10, 20, 30, 40), 4'd9,  "R2 max at first");
    drive(pack5(10, 20, 30, 40, 63), 4'd15, "R4 max at last");
    drive(pack5(42, 42, 42, 42, 42), 4'd3,  "R3 all equal");
    drive(pack5(0, 0, 0, 0, 0),      4'd0,  "R8 all zero");
    drive(pack5(7, 50, 12, 50, 49),  4'd6,  "R3 two-way tie");
    drive(pack5(1, 2, 63, 63, 63),   4'd1,  "R3 three-way tie");
    drive(pack5(0, 0, 0, 0, 1),      4'd8,  "R4 single bit at last");

    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < NA; i++) begin
        a[i*KA +: KA] = (k % 2 == 1) ? KA'($urandom % 8) : KA'($urandom % 64);
      end
      drive(a, KB'($urandom), "R2 random");
    end

    repeat (3) @(posedge clk);
    #2;
    finish_run();
  end

endmodule